// File: doc/BRIEF.md
# Four-Phase Handshake Relay Controller

This controller relays a four-phase (return-to-zero) request from an upstream requester to a downstream server and nests the two handshakes. When the upstream request rises, the controller raises the downstream request. It acknowledges upstream only after the downstream side has acknowledged and then withdrawn its acknowledge. It drops the upstream acknowledge once the upstream request returns to zero. The four steps form a fixed cycle of four states. Each step waits for exactly one input transition.

Both incoming handshake wires may be asynchronous to the local clock. Each passes through a flop synchroniser before its transitions are detected. The environment must let each transition take effect before it applies the next one. Any transition that the current state does not wait for is treated as a protocol violation. A violation raises a sticky error flag and freezes the handshake outputs until reset. A busy output marks the whole time that a relayed transaction is open. All pins are plain level signals. No data path travels with the handshake, so there is no valid/ready interface and no back-pressure rule.

Top module: `hs_relay_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, dn_req_o, up_ack_o, busy_o and proto_err_o are all 0 and the controller waits for an upstream request.
- R2: In the idle state, a rise of up_req_i raises dn_req_o. busy_o rises in the same cycle.
- R3: While dn_req_o is high, a rise of dn_ack_i lowers dn_req_o. up_ack_o stays low.
- R4: After dn_req_o has dropped, a fall of dn_ack_i raises up_ack_o.
- R5: While up_ack_o is high, a fall of up_req_i lowers up_ack_o and returns to idle. dn_req_o and up_ack_o are never high together.
- R6: busy_o is high from the cycle in which dn_req_o rises until the cycle in which up_ack_o falls, and is low otherwise.
- R7: An input level first sampled at rising edge n changes the outputs at rising edge n+2 (default of two synchroniser stages). The outputs are stable in every other cycle.
- R8: Any transition on up_req_i or dn_ack_i that the current state does not wait for sets proto_err_o. The flag stays set until reset.
- R9: Once proto_err_o is set, dn_req_o, up_ack_o and busy_o hold their values, and later input transitions have no effect on them.
- R10: If two transitions reach the detector in the same cycle, this is a violation (R8), even when one of them is the expected one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_i | input | 1 | Upstream request, asynchronous |
| up_ack_o | output | 1 | Upstream acknowledge |
| dn_req_o | output | 1 | Downstream request |
| dn_ack_i | input | 1 | Downstream acknowledge, asynchronous |
| busy_o | output | 1 | A relayed transaction is open |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Each state drives its own distinct output pattern. A wrong state value therefore shows on dn_req_o, up_ack_o or busy_o at the next clock edge, and the per-cycle comparison against the bench model catches it. A wrong expected-event decode shows in one of two ways. Either proto_err_o rises without cause, or the outputs fail to move two edges after a stimulus. An off-by-one in the synchroniser depth shifts every output change by one cycle. The latency check catches that shift on the very first request.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DN_REQ = 2'd1,
    ST_DN_RTZ = 2'd2,
    ST_UP_ACK = 2'd3
  } relay_st_e;

  // Event vector layout: bit 0 up rise, 1 up fall, 2 dn-ack rise, 3 dn-ack fall
  localparam int EV_W        = 4;
  localparam int EV_UP_RISE  = 0;
  localparam int EV_UP_FALL  = 1;
  localparam int EV_ACK_RISE = 2;
  localparam int EV_ACK_FALL = 3;

  function automatic logic [EV_W-1:0] awaited_ev(input relay_st_e st);
    logic [EV_W-1:0] m;
    m = '0;
    case (st)
      ST_IDLE:   m[EV_UP_RISE]  = 1'b1;
      ST_DN_REQ: m[EV_ACK_RISE] = 1'b1;
      ST_DN_RTZ: m[EV_ACK_FALL] = 1'b1;
      default:   m[EV_UP_FALL]  = 1'b1;
    endcase
    return m;
  endfunction

  function automatic relay_st_e advance(input relay_st_e st);
    case (st)
      ST_IDLE:   return ST_DN_REQ;
      ST_DN_REQ: return ST_DN_RTZ;
      ST_DN_RTZ: return ST_UP_ACK;
      default:   return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d[g]};
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/hs_edge.sv
module hs_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/hs_relay_fsm.sv
module hs_relay_fsm
  import hs_relay_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  output relay_st_e       st,
  output logic            err
);
  relay_st_e st_q, st_d;
  logic      err_q, err_d;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    if (!err_q && (ev != '0)) begin
      if (ev == awaited_ev(st_q)) st_d  = advance(st_q);
      else                        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign st  = st_q;
  assign err = err_q;
endmodule

// File: rtl/hs_relay_ctrl.sv
module hs_relay_ctrl
  import hs_relay_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req_i,
  output logic up_ack_o,
  output logic dn_req_o,
  input  logic dn_ack_i,
  output logic busy_o,
  output logic proto_err_o
);
  localparam int NLINES = 2;  // bit 0 upstream request, bit 1 downstream ack

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic [EV_W-1:0]   ev;
  relay_st_e         st;
  logic              err;

  assign raw = {dn_ack_i, up_req_i};

  hs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  hs_edge #(.WIDTH(NLINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
  );

  always_comb begin
    ev              = '0;
    ev[EV_UP_RISE]  = rise[0];
    ev[EV_UP_FALL]  = fall[0];
    ev[EV_ACK_RISE] = rise[1];
    ev[EV_ACK_FALL] = fall[1];
  end

  hs_relay_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ev(ev), .st(st), .err(err)
  );

  assign dn_req_o    = (st == ST_DN_REQ);
  assign up_ack_o    = (st == ST_UP_ACK);
  assign busy_o      = (st != ST_IDLE);
  assign proto_err_o = err;
endmodule

// File: rtl/hs_relay_chk.sv
module hs_relay_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dn_req,
  input logic       up_ack,
  input logic       busy,
  input logic       err,
  input logic [3:0] ev
);
  p_br_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> !$past(busy) && busy);

  p_br_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) && !err |-> !up_ack && busy);

  p_aa_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> !dn_req && !$past(dn_req) && busy);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_req && up_ack));

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(up_ack) && !up_ack);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_idle_ack_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (ev[3:2] != 2'b00) |=> err);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(dn_req) && $stable(up_ack) && $stable(busy));

  p_double_ev_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ev) > 1 |=> err);
endmodule

bind hs_relay_ctrl hs_relay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dn_req(dn_req_o), .up_ack(up_ack_o),
  .busy(busy_o), .err(proto_err_o), .ev(ev)
);

// File: tb/sim_hs_relay_ctrl.sv
`timescale 1ns/1ps
module sim_hs_relay_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, dn_ack = 1'b0;
  logic up_ack, dn_req, busy, perr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_relay_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .up_req_i(up_req), .up_ack_o(up_ack),
    .dn_req_o(dn_req), .dn_ack_i(dn_ack), .busy_o(busy), .proto_err_o(perr)
  );

  // Behavioural reference: inputs seen two edges late, transitions one edge later.
  logic a1, a2, a3, b1, b2, b3;
  int   m_st;
  bit   m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= 0; a2 <= 0; a3 <= 0; b1 <= 0; b2 <= 0; b3 <= 0;
      m_st <= 0; m_err <= 0;
    end else begin
      int n_ev;
      bit ok;
      a1 <= up_req; a2 <= a1; a3 <= a2;
      b1 <= dn_ack; b2 <= b1; b3 <= b2;
      n_ev = int'(a2 != a3) + int'(b2 != b3);
      case (m_st)
        0: ok = a2 && !a3;
        1: ok = b2 && !b3;
        2: ok = !b2 && b3;
        default: ok = !a2 && a3;
      endcase
      if (!m_err && n_ev > 0) begin
        if (n_ev == 1 && ok) m_st <= (m_st + 1) % 4;
        else                 m_err <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 model dn_req", dn_req, m_st == 1);
      chk("R7 model up_ack", up_ack, m_st == 3);
      chk("R6 model busy",   busy,   m_st != 0);
      chk("R8 model err",    perr,   m_err);
      chk("R5 exclusive",    dn_req && up_ack, 1'b0);
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_req = 0; dn_ack = 0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_neg(2);
    chk("R1 reset dn_req", dn_req, 0);
    chk("R1 reset up_ack", up_ack, 0);
    chk("R1 reset busy",   busy,   0);
    chk("R1 reset err",    perr,   0);
    rst_n = 1'b1;
    wait_neg(2);

    for (int k = 0; k < 2; k++) begin
      up_req = 1;
      wait_neg(2);
      chk("R7 not yet at +2 negedges", dn_req, 0);
      wait_neg(1);
      chk("R2 dn_req raised", dn_req, 1);
      chk("R2 busy raised",   busy,   1);
      wait_neg(3);
      dn_ack = 1; wait_neg(5);
      chk("R3 dn_req dropped", dn_req, 0);
      chk("R3 up_ack still low", up_ack, 0);
      dn_ack = 0; wait_neg(5);
      chk("R4 up_ack raised", up_ack, 1);
      chk("R6 busy held", busy, 1);
      up_req = 0; wait_neg(5);
      chk("R5 up_ack dropped", up_ack, 0);
      chk("R6 busy cleared",   busy,   0);
      chk("R8 no error on legal cycle", perr, 0);
    end

    // Unexpected downstream ack while idle
    dn_ack = 1; wait_neg(5);
    chk("R8 error set", perr, 1);
    up_req = 1; wait_neg(5);
    chk("R9 dn_req frozen", dn_req, 0);
    chk("R9 busy frozen",   busy,   0);
    dn_ack = 0; up_req = 0; wait_neg(5);
    chk("R8 error sticky", perr, 1);

    do_reset();
    chk("R1 error cleared by reset", perr, 0);

    // Expected and unexpected transitions together
    up_req = 1; wait_neg(5);
    chk("R2 dn_req before double event", dn_req, 1);
    dn_ack = 1; up_req = 0; wait_neg(5);
    chk("R10 double event is error", perr, 1);
    chk("R9 dn_req frozen high", dn_req, 1);
    dn_ack = 0; wait_neg(5);
    chk("R9 still frozen", dn_req, 1);

    do_reset();
    chk("R1 outputs low after reset", dn_req | up_ack | busy, 0);
    wait_neg(2);
    finish_run();
  end
endmodule